// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block decides, for one hart, whether a conditional store succeeds. When the hart performs a reserving load, the block records which bytes were read. These bytes are held as one aligned 8-byte granule key plus a byte mask. The block also records whether the loaded data was forwarded from one of the hart's own stores that has not yet reached memory. It then watches the stream of stores propagated to shared memory, each tagged with the ID of the hart that issued it. A store from a different hart that touches any reserved byte breaks the reservation. Stores from the owning hart never break it.

A conditional store is resolved in one of three ways. It fails early when it is unpaired or spontaneously abandoned. It fails late when the reservation has been broken or the request is aborted while waiting. Otherwise it succeeds: commit and propagation are signalled together by a single-cycle propagate strobe.

A conditional store is held pending until two things are true: the paired reserving load is finished, and any store forwarded to that load has itself propagated. Every resolution clears the reservation. A new reserving load replaces the reservation outright.

Top module: `lrscMonitor`

## Requirements
- R1: After reset there is no reservation, and `rspValid` and `propStrobe` are low; a conditional store issued right after reset fails early.
- R2: A conditional store whose granule key or byte mask differs from the reservation, or that arrives with no reservation, responds one cycle later with rspOk=0 and rspLate=0. The byte mask is computed from the address bits [2:0] as offset and the size code (0=1, 1=2, 2=4, 3=8 bytes).
- R3: A conditional store with `scSpurious` high responds one cycle later with rspOk=0 and rspLate=0, even when it is correctly paired.
- R4: A paired conditional store succeeds (rspOk=1, rspLate=0) once the reservation is intact, the reserving load is finished and no forwarded source is outstanding. The response comes one cycle after the request when these conditions already hold.
- R5: A propagated store from another hart that overlaps any reserved byte breaks the reservation; the following conditional store responds with rspOk=0 and rspLate=1. This also applies while the conditional store is waiting.
- R6: A propagated store from another hart does not break the reservation when it lies in another granule, or in the same granule with disjoint bytes.
- R7: A propagated store from the owning hart (ID parameter `OWN_HART`) never breaks the reservation.
- R8: While the reserving load is not finished, a paired conditional store produces no response. It responds after `lrFinish` is pulsed.
- R9: When the reserving load was marked forwarded (`lrFwd`), the conditional store waits until a store from the owning hart overlapping the reserved bytes has propagated.
- R10: `scAbort` while a conditional store waits gives rspOk=0 and rspLate=1 one cycle later, with no propagate strobe.
- R11: Any conditional store response clears the reservation. A new reserving load replaces the previous one, so a later store to the old bytes fails early.
- R12: `propStrobe` is high for exactly the cycles in which a successful response is given, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lrValid | input | 1 | Reserving load completes its read this cycle |
| lrAddr | input | ADDR_W | Byte address of the reserving load |
| lrSize | input | 2 | Size code of the reserving load |
| lrFwd | input | 1 | Load data came from an own unpropagated store |
| lrFinish | input | 1 | Reserving load has finished |
| stValid | input | 1 | A store propagated to shared memory this cycle |
| stHart | input | HART_W | Hart ID of the propagated store |
| stAddr | input | ADDR_W | Byte address of the propagated store |
| stSize | input | 2 | Size code of the propagated store |
| scValid | input | 1 | Conditional store request |
| scAddr | input | ADDR_W | Byte address of the conditional store |
| scSize | input | 2 | Size code of the conditional store |
| scSpurious | input | 1 | Request spontaneous early failure |
| scAbort | input | 1 | Spontaneous failure of a waiting conditional store |
| rspValid | output | 1 | Conditional store resolved this cycle |
| rspOk | output | 1 | Conditional store succeeded |
| rspLate | output | 1 | Failure happened after pairing |
| propStrobe | output | 1 | Commit-and-propagate strobe of the store |

## Verification
The bench targets overlap decisions at byte level. These include a store to a neighbouring disjoint word in the same granule and a single-byte hit at the top of an 8-byte reservation. A mask or key compare that is off by one would fail the first or let the second through. The bench also checks that stores from the own hart are ignored; a design that did not filter on hart ID would fail those stores late. It holds requests while the load is unfinished or its forwarded source is outstanding, and confirms no response leaks out early. Finally, it checks reservation replacement and clearing, where a stale reservation would let a later store wrongly succeed.

// File: rtl/lrscPkg.sv
package lrscPkg;
  localparam int GRAN_BYTES = 8;
  localparam int OFF_W = $clog2(GRAN_BYTES);

  typedef struct packed {
    logic setRes;
    logic clearRes;
  } resCmd_t;

  typedef enum logic {ScIdle = 1'b0, ScWait = 1'b1} scState_t;

  // byte lanes touched by an aligned access inside one granule
  function automatic logic [GRAN_BYTES-1:0] byteMask(input logic [OFF_W-1:0] off,
                                                     input logic [1:0] sizeCode);
    logic [GRAN_BYTES-1:0] base;
    case (sizeCode)
      2'd0: base = GRAN_BYTES'(8'h01);
      2'd1: base = GRAN_BYTES'(8'h03);
      2'd2: base = GRAN_BYTES'(8'h0F);
      default: base = GRAN_BYTES'(8'hFF);
    endcase
    return base << off;
  endfunction
endpackage

// File: rtl/lrscDatapath.sv
module lrscDatapath
  import lrscPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HART_W = 2,
  parameter int OWN_HART = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  resCmd_t           cmd,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [1:0]        lrSize,
  input  logic              lrFwd,
  input  logic              lrFinish,
  input  logic              stValid,
  input  logic [HART_W-1:0] stHart,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [1:0]        scSize,
  output logic              resPaired,
  output logic              resBrokenNow,
  output logic              resReady
);
  localparam int KEY_W = ADDR_W - OFF_W;

  logic                  resValid;
  logic [KEY_W-1:0]      resKey;
  logic [GRAN_BYTES-1:0] resMask;
  logic                  resBroken;
  logic                  lrFin;
  logic                  srcPend;

  logic stHit, otherHit, ownHit;

  always_comb begin
    stHit = resValid && stValid && (stAddr[ADDR_W-1:OFF_W] == resKey) &&
            |(byteMask(stAddr[OFF_W-1:0], stSize) & resMask);
    otherHit = stHit && (stHart != HART_W'(OWN_HART));
    ownHit   = stHit && (stHart == HART_W'(OWN_HART));
    resPaired = resValid && (scAddr[ADDR_W-1:OFF_W] == resKey) &&
                (byteMask(scAddr[OFF_W-1:0], scSize) == resMask);
    resBrokenNow = resBroken || otherHit;
    resReady = lrFin && !srcPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resKey    <= '0;
      resMask   <= '0;
      resBroken <= 1'b0;
      lrFin     <= 1'b0;
      srcPend   <= 1'b0;
    end else if (cmd.setRes) begin
      resValid  <= 1'b1;
      resKey    <= lrAddr[ADDR_W-1:OFF_W];
      resMask   <= byteMask(lrAddr[OFF_W-1:0], lrSize);
      resBroken <= 1'b0;
      lrFin     <= lrFinish;
      srcPend   <= lrFwd;
    end else begin
      if (cmd.clearRes) resValid <= 1'b0;
      if (otherHit) resBroken <= 1'b1;
      if (ownHit) srcPend <= 1'b0;
      if (lrFinish) lrFin <= 1'b1;
    end
  end

  // R5
  other_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    (otherHit && !cmd.setRes) |=> (!resValid || resBroken));
  // R7
  own_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resBroken && stValid && stHart == HART_W'(OWN_HART) && !cmd.setRes)
      |=> !resBroken);
  // R11
  clear_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clearRes && !cmd.setRes) |=> !resValid);
endmodule

// File: rtl/lrscCtrl.sv
module lrscCtrl
  import lrscPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lrValid,
  input  logic    scValid,
  input  logic    scSpurious,
  input  logic    scAbort,
  input  logic    resPaired,
  input  logic    resBrokenNow,
  input  logic    resReady,
  output resCmd_t cmd,
  output logic    rspValid,
  output logic    rspOk,
  output logic    rspLate,
  output logic    propStrobe
);
  scState_t state, stateNext;
  logic finish, okNext, lateNext;

  always_comb begin
    stateNext = state;
    finish = 1'b0;
    okNext = 1'b0;
    lateNext = 1'b0;
    case (state)
      ScIdle: begin
        if (scValid) begin
          if (!resPaired || scSpurious) begin
            finish = 1'b1;
          end else if (resBrokenNow) begin
            finish = 1'b1;
            lateNext = 1'b1;
          end else if (resReady) begin
            finish = 1'b1;
            okNext = 1'b1;
          end else begin
            stateNext = ScWait;
          end
        end
      end
      default: begin
        if (scAbort || resBrokenNow) begin
          finish = 1'b1;
          lateNext = 1'b1;
          stateNext = ScIdle;
        end else if (resReady) begin
          finish = 1'b1;
          okNext = 1'b1;
          stateNext = ScIdle;
        end
      end
    endcase
    cmd.setRes = lrValid;
    cmd.clearRes = finish;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ScIdle;
      rspValid   <= 1'b0;
      rspOk      <= 1'b0;
      rspLate    <= 1'b0;
      propStrobe <= 1'b0;
    end else begin
      state      <= stateNext;
      rspValid   <= finish;
      rspOk      <= okNext;
      rspLate    <= lateNext;
      propStrobe <= finish && okNext;
    end
  end

  // R12
  prop_only_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    propStrobe |-> (rspValid && rspOk && !rspLate));
  // R3
  spur_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ScIdle && scValid && scSpurious) |=> (rspValid && !rspOk && !rspLate));
  // R10
  abort_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ScWait && scAbort) |=> (rspValid && rspLate && !propStrobe));
endmodule

// File: rtl/lrscMonitor.sv
module lrscMonitor
  import lrscPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HART_W = 2,
  parameter int OWN_HART = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrValid,
  input  logic [ADDR_W-1:0] lrAddr,
  input  logic [1:0]        lrSize,
  input  logic              lrFwd,
  input  logic              lrFinish,
  input  logic              stValid,
  input  logic [HART_W-1:0] stHart,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [1:0]        scSize,
  input  logic              scSpurious,
  input  logic              scAbort,
  output logic              rspValid,
  output logic              rspOk,
  output logic              rspLate,
  output logic              propStrobe
);
  resCmd_t cmd;
  logic resPaired, resBrokenNow, resReady;

  lrscDatapath #(.ADDR_W(ADDR_W), .HART_W(HART_W), .OWN_HART(OWN_HART)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .lrAddr(lrAddr), .lrSize(lrSize), .lrFwd(lrFwd), .lrFinish(lrFinish),
    .stValid(stValid), .stHart(stHart), .stAddr(stAddr), .stSize(stSize),
    .scAddr(scAddr), .scSize(scSize),
    .resPaired(resPaired), .resBrokenNow(resBrokenNow), .resReady(resReady)
  );

  lrscCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .lrValid(lrValid), .scValid(scValid),
    .scSpurious(scSpurious), .scAbort(scAbort),
    .resPaired(resPaired), .resBrokenNow(resBrokenNow), .resReady(resReady),
    .cmd(cmd), .rspValid(rspValid), .rspOk(rspOk), .rspLate(rspLate),
    .propStrobe(propStrobe)
  );
endmodule

// File: tb/lrscMonitor_tb.sv
module lrscMonitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lrValid = 0, lrFwd = 0, lrFinish = 0, stValid = 0;
  logic scValid = 0, scSpurious = 0, scAbort = 0;
  logic [31:0] lrAddr = 0, stAddr = 0, scAddr = 0;
  logic [1:0] lrSize = 0, stSize = 0, scSize = 0;
  logic [1:0] stHart = 0;
  logic rspValid, rspOk, rspLate, propStrobe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic ok;
    logic late;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lrscMonitor dut_i (
    .clk(clk), .rstN(rstN), .lrValid(lrValid), .lrAddr(lrAddr), .lrSize(lrSize),
    .lrFwd(lrFwd), .lrFinish(lrFinish), .stValid(stValid), .stHart(stHart),
    .stAddr(stAddr), .stSize(stSize), .scValid(scValid), .scAddr(scAddr),
    .scSize(scSize), .scSpurious(scSpurious), .scAbort(scAbort),
    .rspValid(rspValid), .rspOk(rspOk), .rspLate(rspLate), .propStrobe(propStrobe)
  );

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (propStrobe && !rspValid) begin
        total++; bad++;
        $display("FAIL R12 strobe without response act=1 exp=0");
      end
      if (rspValid) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R8 unexpected response act ok=%0b late=%0b exp=none", rspOk, rspLate);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (rspOk !== e.ok || rspLate !== e.late || propStrobe !== e.ok) begin
            bad++;
            $display("FAIL %s act ok=%0b late=%0b prop=%0b exp ok=%0b late=%0b prop=%0b",
                     e.tag, rspOk, rspLate, propStrobe, e.ok, e.late, e.ok);
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLr(input logic [31:0] a, input logic [1:0] s, input logic fwd);
    lrValid = 1; lrAddr = a; lrSize = s; lrFwd = fwd;
    @(negedge clk);
    lrValid = 0; lrFwd = 0;
  endtask

  task automatic doFin();
    lrFinish = 1;
    @(negedge clk);
    lrFinish = 0;
  endtask

  task automatic doStore(input logic [1:0] h, input logic [31:0] a, input logic [1:0] s);
    stValid = 1; stHart = h; stAddr = a; stSize = s;
    @(negedge clk);
    stValid = 0;
  endtask

  task automatic doAbort();
    scAbort = 1;
    @(negedge clk);
    scAbort = 0;
  endtask

  task automatic doSc(input logic [31:0] a, input logic [1:0] s, input logic spur,
                      input logic ok, input logic late, input string tag);
    expItem_t e;
    e.ok = ok; e.late = late; e.tag = tag;
    expQ.push_back(e);
    scValid = 1; scAddr = a; scSize = s; scSpurious = spur;
    @(negedge clk);
    scValid = 0; scSpurious = 0;
  endtask

  task automatic checkPending(input int n, input string tag);
    total++;
    if (expQ.size() != n) begin
      bad++;
      $display("FAIL %s pending act=%0d exp=%0d", tag, expQ.size(), n);
    end
  endtask

  initial begin
    idle(2);
    total++;
    if (rspValid !== 1'b0 || propStrobe !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%0b%0b exp=00", rspValid, propStrobe);
    end
    rstN = 1;
    idle(1);
    doSc(32'h100, 2, 0, 0, 0, "R1 sc after reset");
    idle(2);
    // R4 plain success, R12 strobe
    doLr(32'h100, 2, 0); doFin();
    doSc(32'h100, 2, 0, 1, 0, "R4 success");
    idle(1);
    // R11 cleared after response
    doSc(32'h100, 2, 0, 0, 0, "R11 cleared reservation");
    idle(1);
    // R2 byte mismatch
    doLr(32'h100, 2, 0); doFin();
    doSc(32'h104, 2, 0, 0, 0, "R2 unpaired bytes");
    idle(1);
    // R5 other hart hits top byte
    doLr(32'h200, 3, 0); doFin();
    doStore(2'd2, 32'h207, 0);
    doSc(32'h200, 3, 0, 0, 1, "R5 broken reservation");
    idle(1);
    // R6 disjoint bytes and other granule
    doLr(32'h200, 2, 0); doFin();
    doStore(2'd2, 32'h204, 2);
    doStore(2'd0, 32'h300, 3);
    doSc(32'h200, 2, 0, 1, 0, "R6 no overlap");
    idle(1);
    // R7 own hart overlapping store
    doLr(32'h208, 1, 0); doFin();
    doStore(2'd1, 32'h208, 1);
    doSc(32'h208, 1, 0, 1, 0, "R7 own store");
    idle(1);
    // R3 spontaneous early failure
    doLr(32'h40, 2, 0); doFin();
    doSc(32'h40, 2, 1, 0, 0, "R3 spurious");
    idle(1);
    // R8 wait for finish
    doLr(32'h80, 2, 0);
    doSc(32'h80, 2, 0, 1, 0, "R8 after finish");
    idle(4);
    checkPending(1, "R8 unfinished load");
    doFin();
    idle(3);
    checkPending(0, "R8 resolved");
    // R9 forwarded source outstanding
    doLr(32'h80, 2, 1); doFin();
    doSc(32'h80, 2, 0, 1, 0, "R9 after source propagates");
    idle(3);
    checkPending(1, "R9 forwarded source");
    doStore(2'd1, 32'h80, 2);
    idle(3);
    checkPending(0, "R9 resolved");
    // R10 abort while waiting
    doLr(32'h90, 2, 0);
    doSc(32'h90, 2, 0, 0, 1, "R10 abort");
    idle(2);
    doAbort();
    idle(2);
    // R5 break while waiting
    doLr(32'h90, 2, 0);
    doSc(32'h90, 2, 0, 0, 1, "R5 broken while waiting");
    idle(2);
    doStore(2'd3, 32'h92, 0);
    idle(2);
    // R11 replacement
    doLr(32'hA0, 2, 0);
    doLr(32'hB0, 2, 0); doFin();
    doSc(32'hA0, 2, 0, 0, 0, "R11 replaced reservation");
    idle(3);
    checkPending(0, "R12 all responses seen");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule